// File: doc/BRIEF.md
# Multi-Mode Timer/Counter with Power-of-Two Prescaler

This block is a 16-bit timer/counter steered by a single 8-bit control byte. The byte picks one of four operating modes (free-running software timer, pulse-width modulation, capture/compare, and external event counting). It also sets a power-of-two clock divider, and the active edge for the two capture pins and for the event pin. Bit 7 of the same byte is a sticky wrap flag for a separate 8-bit real-time counter. That counter advances on its own increment strobe and has no link to the main timer.

Software writes the control byte and reads it back. Duty, period and compare values are presented on plain configuration pins. The count, both captured values, the PWM output and the sticky status flags are visible on output pins. The capture and event pins are asynchronous. Each passes through a two-flop synchronizer and an edge detector before it can act. No data stream enters or leaves the block, so it has no valid/ready interface: every pin is a plain control, configuration or status signal, sampled or updated on each rising clock edge.

Top module: `multi_timer`

## Requirements
- R1: After reset the control byte reads 00h, and the count, the real-time counter, every flag, both capture values and the PWM output are all 0.
- R2: Control byte layout: bit 7 wrap flag, bit 6 capture edge, bit 5 event edge, bits 4:2 prescaler select, bits 1:0 mode. Bits 6:0 read back as written. Mode codes: 00 software timer, 01 PWM, 10 capture/compare, 11 event counting.
- R3: With prescaler select n in the timer, PWM or capture/compare mode, the count advances once every 2^n clocks. A write that changes the select restarts the divider, so the first advance comes exactly 2^n clocks after the write edge.
- R4: In software timer mode the count wraps from all ones to 0.
- R5: Bit 7 goes to 1 on the clock where the real-time counter wraps from FFh to 00h. Writing 0 to bit 7 clears it. Writing 1 leaves it unchanged. A wrap on the same clock as a clearing write leaves it set.
- R6: In capture/compare mode, the selected edge on capture pin 1 (or 2) copies the count held just before that clock edge into capture value 1 (or 2), and sets capture flag 1 (or 2). Bit 6 = 1 selects rising edges and 0 selects falling edges, for both pins. The other edge, and any capture edge in another mode, changes nothing.
- R7: In capture/compare mode the compare flag is set once the count equals the compare value.
- R8: In PWM mode the count runs from 0 to the active period value and then returns to 0. The output is high while the count is below the active duty value. The active duty and period are taken from the configuration pins at each return to 0. In any other mode the output is low.
- R9: In event mode the count advances by one per selected edge on the event pin (bit 5 = 1 rising, 0 falling), ignores the prescaler, and ignores the other edge.
- R10: A capture or event pin change made between clock edges takes effect on the third rising edge after it.
- R11: Bits 0, 1 and 2 of the flag-clear input clear capture flag 1, capture flag 2 and the compare flag. A new set on the same clock wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write value |
| ctl_rdata | output | 8 | Control byte read value |
| rtc_inc | input | 1 | Real-time counter increment strobe |
| rtc_value | output | RTC_W | Real-time counter value |
| cap1_pin | input | 1 | Capture pin 1 (asynchronous) |
| cap2_pin | input | 1 | Capture pin 2 (asynchronous) |
| evt_pin | input | 1 | External event pin (asynchronous) |
| duty_cfg | input | CNT_W | PWM duty value |
| period_cfg | input | CNT_W | PWM period value |
| compare_cfg | input | CNT_W | Compare value |
| flag_clr | input | 3 | Flag clear strobes: cmp, cap2, cap1 |
| count | output | CNT_W | Main counter value |
| cap1_value | output | CNT_W | Capture value 1 |
| cap2_value | output | CNT_W | Capture value 2 |
| cap1_flag | output | 1 | Capture flag 1 |
| cap2_flag | output | 1 | Capture flag 2 |
| cmp_flag | output | 1 | Compare flag |
| pwm_out | output | 1 | PWM output |

## Verification
The bench builds the block with CNT_W = 8, which puts the all-ones-to-zero wrap of the software timer within 256 clocks. It also keeps PWM periods and compare distances small enough to follow every step. RTC_W stays at 8 and SYNC_STAGES at 2, so the real-time wrap and the three-edge pin latency are checked at their default sizes. All eight prescaler selects, from divide by 1 to divide by 128, are reached through random changes of the select field.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int PSEL_W = 3;

  typedef enum logic [1:0] {
    MODE_SOFT   = 2'b00,
    MODE_PWM    = 2'b01,
    MODE_CAPCMP = 2'b10,
    MODE_EVENT  = 2'b11
  } mt_mode_e;

  typedef struct packed {
    logic              wrap_flag;
    logic              cap_rise;
    logic              evt_rise;
    logic [PSEL_W-1:0] psel;
    mt_mode_e          mode;
  } mt_ctl_t;
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  assign limit = ~({DIV_W{1'b1}} << sel);
  assign tick  = !restart && (div_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         div_q <= '0;
    else if (restart || div_q == limit) div_q <= '0;
    else                                div_q <= div_q + 1'b1;
  end

  // R3: a restart leaves exactly one full new period before the next tick
  a_r3_restart_phase: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (restart || (tick == (sel == '0))));
endmodule

// File: rtl/mt_edge_det.sv
module mt_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic hit
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              level;

  assign level = sync_q[STAGES-1];
  assign hit   = rise_sel ? (level && !prev_q) : (!level && prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= level;
    end
  end
endmodule

// File: rtl/mt_count_core.sv
module mt_count_core
  import mt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  mt_mode_e              mode,
  input  logic                  tick,
  input  logic [1:0]            cap_hit,
  input  logic                  evt_hit,
  input  logic [CNT_W-1:0]      duty_cfg,
  input  logic [CNT_W-1:0]      period_cfg,
  input  logic [CNT_W-1:0]      compare_cfg,
  input  logic [2:0]            flag_clr,
  output logic [CNT_W-1:0]      count,
  output logic [1:0][CNT_W-1:0] cap_val,
  output logic [1:0]            cap_flag,
  output logic                  cmp_flag,
  output logic                  pwm_out
);
  logic [CNT_W-1:0] duty_act, per_act;
  logic             pwm_wrap;
  logic             in_capcmp;

  assign in_capcmp = (mode == MODE_CAPCMP);
  assign pwm_wrap  = (mode == MODE_PWM) && tick && (count >= per_act);
  assign pwm_out   = (mode == MODE_PWM) && (count < duty_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      duty_act <= '0;
      per_act  <= '0;
    end else begin
      unique case (mode)
        MODE_SOFT, MODE_CAPCMP: if (tick) count <= count + 1'b1;
        MODE_PWM: begin
          if (pwm_wrap) begin
            count    <= '0;
            duty_act <= duty_cfg;
            per_act  <= period_cfg;
          end else if (tick) begin
            count <= count + 1'b1;
          end
        end
        MODE_EVENT: if (evt_hit) count <= count + 1'b1;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap_val[i]  <= '0;
        cap_flag[i] <= 1'b0;
      end else begin
        if (in_capcmp && cap_hit[i]) cap_val[i] <= count;
        cap_flag[i] <= (cap_flag[i] && !flag_clr[i]) || (in_capcmp && cap_hit[i]);
      end
    end

    // R6: a capture edge latches the pre-edge count and raises its flag
    a_r6_cap_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (in_capcmp && cap_hit[i]) |=> (cap_flag[i] && cap_val[i] == $past(count)));
    // R11: a clear with no competing set drops the flag
    a_r11_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[i] && !(in_capcmp && cap_hit[i])) |=> !cap_flag[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_flag <= 1'b0;
    else        cmp_flag <= (cmp_flag && !flag_clr[2]) || (in_capcmp && count == compare_cfg);
  end

  // R4: the software timer rolls over to zero
  a_r4_soft_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SOFT && tick && (&count)) |=> (count == '0));
  // R8: reaching the active period returns the PWM count to zero
  a_r8_pwm_return: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PWM && tick && count >= per_act) |=> (count == '0));
  // R9: in event mode nothing but an event edge moves the count
  a_r9_event_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_EVENT && !evt_hit) |=> $stable(count));
  // R7: compare equality in capture/compare mode raises the flag
  a_r7_cmp_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_capcmp && count == compare_cfg) |=> cmp_flag);
endmodule

// File: rtl/multi_timer.sv
module multi_timer
  import mt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int RTC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  output logic [7:0]       ctl_rdata,
  input  logic             rtc_inc,
  output logic [RTC_W-1:0] rtc_value,
  input  logic             cap1_pin,
  input  logic             cap2_pin,
  input  logic             evt_pin,
  input  logic [CNT_W-1:0] duty_cfg,
  input  logic [CNT_W-1:0] period_cfg,
  input  logic [CNT_W-1:0] compare_cfg,
  input  logic [2:0]       flag_clr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap1_value,
  output logic [CNT_W-1:0] cap2_value,
  output logic             cap1_flag,
  output logic             cap2_flag,
  output logic             cmp_flag,
  output logic             pwm_out
);
  localparam int N_PINS = 3;

  mt_ctl_t                  ctl_q;
  mt_ctl_t                  wr_view;
  logic                     rtc_wrap;
  logic                     ps_restart;
  logic                     tick;
  logic [N_PINS-1:0]        pins, pol, hits;
  logic [1:0][CNT_W-1:0]    cap_val;
  logic [1:0]               cap_flag;

  assign wr_view    = mt_ctl_t'(ctl_wdata);
  assign ps_restart = ctl_we && (wr_view.psel != ctl_q.psel);
  assign rtc_wrap   = rtc_inc && (&rtc_value);
  assign ctl_rdata  = ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      if (ctl_we) begin
        ctl_q.cap_rise <= wr_view.cap_rise;
        ctl_q.evt_rise <= wr_view.evt_rise;
        ctl_q.psel     <= wr_view.psel;
        ctl_q.mode     <= wr_view.mode;
      end
      ctl_q.wrap_flag <= rtc_wrap || (ctl_q.wrap_flag && !(ctl_we && !wr_view.wrap_flag));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rtc_value <= '0;
    else if (rtc_inc) rtc_value <= rtc_value + 1'b1;
  end

  mt_prescaler #(.SEL_W(PSEL_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart(ps_restart), .sel(ctl_q.psel), .tick(tick)
  );

  assign pins = {evt_pin, cap2_pin, cap1_pin};
  assign pol  = {ctl_q.evt_rise, ctl_q.cap_rise, ctl_q.cap_rise};

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    mt_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(pins[p]), .rise_sel(pol[p]), .hit(hits[p])
    );
  end

  mt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(ctl_q.mode), .tick(tick),
    .cap_hit(hits[1:0]), .evt_hit(hits[2]),
    .duty_cfg(duty_cfg), .period_cfg(period_cfg), .compare_cfg(compare_cfg),
    .flag_clr(flag_clr), .count(count), .cap_val(cap_val),
    .cap_flag(cap_flag), .cmp_flag(cmp_flag), .pwm_out(pwm_out)
  );

  assign cap1_value = cap_val[0];
  assign cap2_value = cap_val[1];
  assign cap1_flag  = cap_flag[0];
  assign cap2_flag  = cap_flag[1];

  // R5: a real-time wrap always leaves the flag set
  a_r5_wrap_set: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_wrap |=> ctl_rdata[7]);
  // R5: a clearing write with no wrap drops the flag
  a_r5_wrap_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[7] && !rtc_wrap) |=> !ctl_rdata[7]);
  // R2: control bits below the flag follow the write
  a_r2_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_rdata[6:0] == $past(ctl_wdata[6:0])));
endmodule

// File: tb/test_multi_timer.sv
module test_multi_timer;
  localparam int CW = 8;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          ctl_we = 1'b0;
  logic [7:0]    ctl_wdata = '0, ctl_rdata;
  logic          rtc_inc = 1'b0;
  logic [7:0]    rtc_value;
  logic          cap1_pin = 1'b0, cap2_pin = 1'b0, evt_pin = 1'b0;
  logic [CW-1:0] duty_cfg = '0, period_cfg = '0, compare_cfg = '0;
  logic [2:0]    flag_clr = '0;
  logic [CW-1:0] count, cap1_value, cap2_value;
  logic          cap1_flag, cap2_flag, cmp_flag, pwm_out;

  int total = 0;
  int bad   = 0;

  multi_timer #(.CNT_W(CW), .RTC_W(8), .SYNC_STAGES(2)) i_multi_timer (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .rtc_inc(rtc_inc), .rtc_value(rtc_value), .cap1_pin(cap1_pin), .cap2_pin(cap2_pin),
    .evt_pin(evt_pin), .duty_cfg(duty_cfg), .period_cfg(period_cfg), .compare_cfg(compare_cfg),
    .flag_clr(flag_clr), .count(count), .cap1_value(cap1_value), .cap2_value(cap2_value),
    .cap1_flag(cap1_flag), .cap2_flag(cap2_flag), .cmp_flag(cmp_flag), .pwm_out(pwm_out)
  );

  always #5ns clk = ~clk;

  function automatic int ticks_per_step(int sel);
    return 1 << sel;
  endfunction

  function automatic logic pwm_expect(int k, int duty);
    return k < duty;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    ctl_we = 1'b1;
    ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cap1_pin = 0; cap2_pin = 0; evt_pin = 0; rtc_inc = 0; flag_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_cap(input int idx, input logic v);
    if (idx == 0) cap1_pin = v; else cap2_pin = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R-watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [CW-1:0] c0, cnt, exp_cnt;
    int cur_ps, n, per, dty, per2, dty2;
    logic p, lvl;
    void'($urandom(32'd4242));

    // R1 reset state
    do_reset();
    chk("R1 ctl", ctl_rdata, 8'h00);
    chk("R1 count", count, 0);
    chk("R1 rtc", rtc_value, 0);
    chk("R1 flags", {cap1_flag, cap2_flag, cmp_flag, pwm_out}, 0);
    chk("R1 caps", {cap1_value, cap2_value}, 0);

    // R2 layout and readback; bit 7 cannot be set by a write
    wr_ctl(8'h55);
    chk("R2 readback", ctl_rdata, 8'h55);
    wr_ctl(8'hEA);
    chk("R2 bit7 write", ctl_rdata, 8'h6A);

    // R3 prescaler, random selects, restart on change
    do_reset();
    cur_ps = 0;
    for (int it = 0; it < 10; it++) begin
      n = (cur_ps + 1 + int'($urandom_range(0, 6))) % 8;
      if (it == 0) n = 7;
      wr_ctl({3'b000, n[2:0], 2'b00});
      cur_ps = n;
      c0 = count;
      repeat (ticks_per_step(n) - 1) @(negedge clk);
      chk("R3 hold before tick", count, c0);
      @(negedge clk);
      chk("R3 first tick", count, CW'(c0 + 1));
      repeat (ticks_per_step(n)) @(negedge clk);
      chk("R3 second tick", count, CW'(c0 + 2));
    end

    // R4 software timer wrap
    do_reset();
    for (int i = 0; i < 300 && count != 8'hFE; i++) @(negedge clk);
    chk("R4 at FE", count, 8'hFE);
    @(negedge clk); chk("R4 at FF", count, 8'hFF);
    @(negedge clk); chk("R4 wrap", count, 8'h00);

    // R5 real-time counter wrap flag
    do_reset();
    rtc_inc = 1'b1;
    repeat (255) @(negedge clk);
    rtc_inc = 1'b0;
    chk("R5 rtc FF", rtc_value, 8'hFF);
    chk("R5 no flag yet", ctl_rdata[7], 0);
    rtc_inc = 1'b1; @(negedge clk); rtc_inc = 1'b0;
    chk("R5 rtc wrapped", rtc_value, 8'h00);
    chk("R5 flag set", ctl_rdata[7], 1);
    wr_ctl(8'h80);
    chk("R5 write1 keeps", ctl_rdata[7], 1);
    wr_ctl(8'h00);
    chk("R5 write0 clears", ctl_rdata[7], 0);
    wr_ctl(8'h80);
    chk("R5 write1 no set", ctl_rdata[7], 0);
    rtc_inc = 1'b1;
    repeat (255) @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = 8'h00;
    @(negedge clk);
    ctl_we = 1'b0; rtc_inc = 1'b0;
    chk("R5 set wins", ctl_rdata[7], 1);

    // R6 R10 R11 capture
    do_reset();
    p = 1'($urandom_range(0, 1));
    wr_ctl({1'b0, p, 1'b0, 3'b000, 2'b10});
    if (!p) begin
      cap1_pin = 1; cap2_pin = 1;
      repeat (5) @(negedge clk);
      chk("R6 wrong edge ignored", {cap1_flag, cap2_flag}, 0);
    end
    for (int r = 0; r < 6; r++) begin
      int idx = r % 2;
      set_cap(idx, p);
      @(negedge clk);
      @(negedge clk);
      cnt = count;
      chk("R10 not yet", idx ? cap2_flag : cap1_flag, 0);
      @(negedge clk);
      chk("R6 R10 flag", idx ? cap2_flag : cap1_flag, 1);
      chk("R6 value", idx ? cap2_value : cap1_value, cnt);
      set_cap(idx, !p);
      flag_clr = 3'(1 << idx);
      @(negedge clk);
      flag_clr = '0;
      repeat (3 + int'($urandom_range(0, 4))) @(negedge clk);
      chk("R11 R6 cleared, idle edge ignored", idx ? cap2_flag : cap1_flag, 0);
    end

    // R7 compare
    flag_clr = 3'b100; @(negedge clk); flag_clr = '0;
    compare_cfg = CW'(count + 10);
    repeat (5) @(negedge clk);
    chk("R7 before match", cmp_flag, 0);
    repeat (10) @(negedge clk);
    chk("R7 match", cmp_flag, 1);

    // R6 capture ignored outside capture/compare mode
    wr_ctl({1'b0, p, 1'b0, 3'b000, 2'b00});
    c0 = cap1_value;
    cap1_pin = p; repeat (5) @(negedge clk);
    cap1_pin = !p; repeat (5) @(negedge clk);
    chk("R6 other mode flag", cap1_flag, 0);
    chk("R6 other mode value", cap1_value, c0);

    // R8 PWM
    do_reset();
    per = int'($urandom_range(3, 20));
    dty = int'($urandom_range(1, per));
    duty_cfg = CW'(dty); period_cfg = CW'(per);
    wr_ctl(8'b0000_0001);
    begin
      logic seen = 0;
      for (int i = 0; i < 300 && !(seen && count == 0); i++) begin
        if (count != 0) seen = 1;
        @(negedge clk);
      end
    end
    for (int k = 0; k < 3 * (per + 1); k++) begin
      chk("R8 count", count, CW'(k % (per + 1)));
      chk("R8 out", pwm_out, pwm_expect(k % (per + 1), dty));
      @(negedge clk);
    end
    per2 = int'($urandom_range(3, 20));
    dty2 = int'($urandom_range(0, per2 + 1));
    @(negedge clk);
    duty_cfg = CW'(dty2); period_cfg = CW'(per2);
    for (int k = 1; k <= per; k++) begin
      chk("R8 old settings until wrap", {count, 7'd0, pwm_out}, {CW'(k), 7'd0, pwm_expect(k, dty)});
      @(negedge clk);
    end
    for (int k = 0; k < 2 * (per2 + 1); k++) begin
      chk("R8 new settings", {count, 7'd0, pwm_out},
          {CW'(k % (per2 + 1)), 7'd0, pwm_expect(k % (per2 + 1), dty2)});
      @(negedge clk);
    end
    wr_ctl(8'b0000_0000);
    chk("R8 low in other mode", pwm_out, 0);

    // R9 event counting, both polarities, prescaler ignored
    do_reset();
    wr_ctl(8'b0011_1111);
    exp_cnt = count;
    lvl = 0;
    for (int i = 0; i < 40; i++) begin
      lvl = !lvl; evt_pin = lvl;
      if (lvl) exp_cnt = CW'(exp_cnt + 1);
      repeat (int'($urandom_range(1, 4))) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk("R9 rising count", count, exp_cnt);
    wr_ctl(8'b0000_1011);
    for (int i = 0; i < 40; i++) begin
      lvl = !lvl; evt_pin = lvl;
      if (!lvl) exp_cnt = CW'(exp_cnt + 1);
      repeat (int'($urandom_range(1, 4))) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk("R9 falling count", count, exp_cnt);
    repeat (20) @(negedge clk);
    chk("R9 no prescaler advance", count, exp_cnt);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule